// File: doc/BRIEF.md
# Decoder Control and Status Register File

This block is the CPU-facing register bank of a bitstream decoder engine. A CPU-side bus issues single-cycle read and write requests against six word registers: an event flag register, an interrupt mask, a control word, an input DMA address, an input byte count and a header output address. The decoder core feeds it one-cycle pulses for command completion, start-code detection, bitstream errors, command issue and input count decrements, plus two level signals that say whether each input buffer is empty.

The flags drive a level interrupt through the mask. The control word carries a restart code that reaches the core only through a strobed copy, and the same strobe decides whether the byte-order and DMA-done-mode bits may change. The input-done flag fires when the byte count drains to zero, optionally waiting until both input buffers are empty.

Register word offsets on `req_addr`: 0 flags, 1 interrupt mask, 2 control, 3 input address, 4 input count, 5 header address; offsets 6 and 7 are unmapped.

Top module: `dec_csr_regs`

## Requirements
- R1: After reset every register reads 0, except control, which reads 0x00000001 (byte-order bit at 1), and `little_endian` is 1 while `irq` and `restart_code` are 0.
- R2: Flag bits 1 (start code seen), 2 (bitstream error) and 3 (input DMA done) set on their core event and clear when the CPU writes offset 0 with a 1 in that bit; a 0 in that bit leaves it unchanged.
- R3: Flag bit 0 (command done) sets on `ev_cmd_done` and clears only on `cmd_issue`; a CPU write of 1 to bit 0 has no effect.
- R4: When a core set event and a clearing condition hit the same flag in the same cycle, the flag ends up 1.
- R5: The mask register holds 8 bits (bits 7:0, upper bits read 0) and `irq` is 1 exactly when some flag bit and the mask bit at the same position are both 1.
- R6: A control write with bit 16 at 1 copies bits 15:8 of that write to `restart_code`; control bit 16 always reads 0 and bits 15:8 read back the last written code field.
- R7: Control bit 0 (`little_endian`) and bit 2 (`dma_done_mode`) take the written value only when the same write has bit 16 at 0.
- R8: The input count holds 15 bits (bits 14:0, upper bits read 0); a `dma_dec` pulse lowers a non-zero count by one, a zero count stays zero, and a CPU count write in the same cycle takes precedence over the decrement.
- R9: With `dma_done_mode` at 0, flag bit 3 sets on the cycle after a decrement takes the count from 1 to 0.
- R10: With `dma_done_mode` at 1, a decrement to zero while a buffer is non-empty leaves flag bit 3 clear and holds a pending condition; flag bit 3 sets after the first cycle in which both `buf0_empty` and `buf1_empty` are 1.
- R11: A CPU write of a non-zero count cancels a pending input-done condition, so a later both-empty cycle does not set flag bit 3.
- R12: Writes to the input and header address registers drop the two low bits, which always read 0.
- R13: A read request returns `rd_valid` at 1 with the register value in `rd_data` on the next cycle; unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Register word offset |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after read request) |
| rd_data | output | 32 | Read data |
| ev_cmd_done | input | 1 | Core pulse: command finished successfully |
| ev_start_code | input | 1 | Core pulse: start code seen |
| ev_bs_error | input | 1 | Core pulse: illegal code in bitstream |
| cmd_issue | input | 1 | Core pulse: new command issued |
| dma_dec | input | 1 | Core pulse: one input byte consumed |
| buf0_empty | input | 1 | Input buffer 0 is empty |
| buf1_empty | input | 1 | Input buffer 1 is empty |
| irq | output | 1 | Level interrupt |
| little_endian | output | 1 | Byte order to core, 1 little-endian |
| dma_done_mode | output | 1 | Input-done rule, 1 waits for empty buffers |
| restart_code | output | 8 | Working restart code for the core |
| in_addr | output | 32 | Input DMA address |
| in_count | output | CNT_W | Input DMA byte count |
| hdr_addr | output | 32 | Header output address |

## Verification
The hardest state to reach from the ports is the pending input-done condition: the count must drain to zero by decrements while the done mode is 1 and at least one buffer reports non-empty, and then either both buffers empty out or a fresh non-zero count lands first. Directed sequences build each of these orderings explicitly, and the random phase writes only counts of 0 to 3 with decrements on half the cycles and buffer levels toggling at random, so drains, pending holds and cancellations recur throughout the run alongside set-versus-clear collisions on the flags.

// File: rtl/dec_csr_pkg.sv
package dec_csr_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned NFLAG  = 4;
  localparam int unsigned CODE_W = 8;

  // register word offsets
  localparam int unsigned OFS_FLAGS = 0;
  localparam int unsigned OFS_MASK  = 1;
  localparam int unsigned OFS_CTRL  = 2;
  localparam int unsigned OFS_IADDR = 3;
  localparam int unsigned OFS_ICNT  = 4;
  localparam int unsigned OFS_HADDR = 5;

  // flag bit positions
  localparam int unsigned FLG_CMD  = 0;
  localparam int unsigned FLG_SC   = 1;
  localparam int unsigned FLG_ERR  = 2;
  localparam int unsigned FLG_DMA  = 3;

  // control field positions
  localparam int unsigned CTL_LE   = 0;
  localparam int unsigned CTL_MODE = 2;
  localparam int unsigned CTL_CODE = 8;
  localparam int unsigned CTL_STB  = 16;

  function automatic logic [DATA_W-1:0] word_align(input logic [DATA_W-1:0] a);
    return {a[DATA_W-1:2], 2'b00};
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_image(input logic [CODE_W-1:0] code,
                                                   input logic mode, input logic le);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CTL_CODE +: CODE_W] = code;
    v[CTL_MODE] = mode;
    v[CTL_LE]   = le;
    return v;
  endfunction

endpackage

// File: rtl/dec_csr_status.sv
module dec_csr_status
  import dec_csr_pkg::*;
#(
  parameter int unsigned EN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_ev,
  input  logic             w1c_wr,
  input  logic [NFLAG-1:0] w1c_data,
  input  logic             cmd_issue,
  input  logic             en_wr,
  input  logic [EN_W-1:0]  en_wdata,
  output logic [NFLAG-1:0] flags,
  output logic [EN_W-1:0]  en,
  output logic             irq
);

  localparam int unsigned PAD_W = EN_W - NFLAG;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic q;
    if (i == FLG_CMD) begin : g_cmd
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= 1'b0;
        else if (set_ev[i]) q <= 1'b1;
        else if (cmd_issue) q <= 1'b0;
      end
    end else begin : g_w1c
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        q <= 1'b0;
        else if (set_ev[i])                q <= 1'b1;
        else if (w1c_wr && w1c_data[i])    q <= 1'b0;
      end
    end
    assign flags[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en <= '0;
    else if (en_wr) en <= en_wdata;
  end

  logic [EN_W-1:0] pending_irq;
  assign pending_irq = {{PAD_W{1'b0}}, flags} & en;
  assign irq = |pending_irq;

  AST_CMD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FLG_CMD] && !cmd_issue |=> flags[FLG_CMD]); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev[FLG_ERR] |=> flags[FLG_ERR]); // R4
  AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[FLG_SC]) |-> $past(w1c_wr && w1c_data[FLG_SC])); // R2

endmodule

// File: rtl/dec_csr_ctrl.sv
module dec_csr_ctrl
  import dec_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CODE_W-1:0] code_field,
  output logic [CODE_W-1:0] code_work,
  output logic              le,
  output logic              mode
);

  logic strobe;
  assign strobe = wdata[CTL_STB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_field <= '0;
      code_work  <= '0;
      le         <= 1'b1;
      mode       <= 1'b0;
    end else if (ctrl_wr) begin
      code_field <= wdata[CTL_CODE +: CODE_W];
      if (strobe) begin
        code_work <= wdata[CTL_CODE +: CODE_W];
      end else begin
        le   <= wdata[CTL_LE];
        mode <= wdata[CTL_MODE];
      end
    end
  end

  AST_STROBE_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wdata[CTL_STB] |=> $stable(le) && $stable(mode)); // R7
  AST_STROBE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wdata[CTL_STB] |=> code_work == $past(wdata[CTL_CODE +: CODE_W])); // R6

endmodule

// File: rtl/dec_csr_dma.sv
module dec_csr_dma
  import dec_csr_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr,
  input  logic              iaddr_wr,
  input  logic              haddr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dec,
  input  logic              buf0_empty,
  input  logic              buf1_empty,
  input  logic              mode,
  output logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] iaddr,
  output logic [DATA_W-1:0] haddr,
  output logic              done_set
);

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c,
                                                  input logic wr, input logic [CNT_W-1:0] w,
                                                  input logic fire);
    if (wr)   return w;
    if (fire) return c - CNT_W'(1);
    return c;
  endfunction

  logic [CNT_W-1:0] cnt_wval;
  logic             dec_fire;
  logic             reach_zero;
  logic             both_empty;
  logic             pend_q;

  assign cnt_wval   = wdata[CNT_W-1:0];
  assign dec_fire   = dec && !cnt_wr && (cnt != '0);
  assign reach_zero = dec_fire && (cnt == CNT_W'(1));
  assign both_empty = buf0_empty && buf1_empty;
  assign done_set   = mode ? ((reach_zero || pend_q) && both_empty) : reach_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= count_next(cnt, cnt_wr, cnt_wval, dec_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pend_q <= 1'b0;
    else if (cnt_wr && cnt_wval != '0)   pend_q <= 1'b0;
    else if (!mode || done_set)          pend_q <= 1'b0;
    else if (reach_zero)                 pend_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iaddr <= '0;
      haddr <= '0;
    end else begin
      if (iaddr_wr) iaddr <= word_align(wdata);
      if (haddr_wr) haddr <= word_align(wdata);
    end
  end

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    dec && !cnt_wr && cnt != '0 |=> cnt == $past(cnt) - CNT_W'(1)); // R8
  AST_DONE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done_set && mode |-> buf0_empty && buf1_empty); // R10
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 && !cnt_wr |=> cnt == '0); // R8

endmodule

// File: rtl/dec_csr_regs.sv
module dec_csr_regs
  import dec_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CNT_W  = 15,
  parameter int unsigned EN_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              ev_cmd_done,
  input  logic              ev_start_code,
  input  logic              ev_bs_error,
  input  logic              cmd_issue,
  input  logic              dma_dec,
  input  logic              buf0_empty,
  input  logic              buf1_empty,
  output logic              irq,
  output logic              little_endian,
  output logic              dma_done_mode,
  output logic [7:0]        restart_code,
  output logic [31:0]       in_addr,
  output logic [CNT_W-1:0]  in_count,
  output logic [31:0]       hdr_addr
);

  localparam int unsigned NREG = 6;

  logic             wr_en;
  logic             rd_en;
  logic [NREG-1:0]  wr_sel;
  logic [NFLAG-1:0] flags;
  logic [EN_W-1:0]  en;
  logic [NFLAG-1:0] set_ev;
  logic             dma_done_set;
  logic [CODE_W-1:0] code_field;

  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;

  for (genvar r = 0; r < NREG; r++) begin : g_sel
    assign wr_sel[r] = wr_en && (req_addr == ADDR_W'(r));
  end

  always_comb begin
    set_ev          = '0;
    set_ev[FLG_CMD] = ev_cmd_done;
    set_ev[FLG_SC]  = ev_start_code;
    set_ev[FLG_ERR] = ev_bs_error;
    set_ev[FLG_DMA] = dma_done_set;
  end

  dec_csr_status #(.EN_W(EN_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_ev    (set_ev),
    .w1c_wr    (wr_sel[OFS_FLAGS]),
    .w1c_data  (req_wdata[NFLAG-1:0]),
    .cmd_issue (cmd_issue),
    .en_wr     (wr_sel[OFS_MASK]),
    .en_wdata  (req_wdata[EN_W-1:0]),
    .flags     (flags),
    .en        (en),
    .irq       (irq)
  );

  dec_csr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (wr_sel[OFS_CTRL]),
    .wdata      (req_wdata),
    .code_field (code_field),
    .code_work  (restart_code),
    .le         (little_endian),
    .mode       (dma_done_mode)
  );

  dec_csr_dma #(.CNT_W(CNT_W)) u_dma (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_wr     (wr_sel[OFS_ICNT]),
    .iaddr_wr   (wr_sel[OFS_IADDR]),
    .haddr_wr   (wr_sel[OFS_HADDR]),
    .wdata      (req_wdata),
    .dec        (dma_dec),
    .buf0_empty (buf0_empty),
    .buf1_empty (buf1_empty),
    .mode       (dma_done_mode),
    .cnt        (in_count),
    .iaddr      (in_addr),
    .haddr      (hdr_addr),
    .done_set   (dma_done_set)
  );

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (req_addr)
      ADDR_W'(OFS_FLAGS): rd_mux = {{(32-NFLAG){1'b0}}, flags};
      ADDR_W'(OFS_MASK):  rd_mux = {{(32-EN_W){1'b0}}, en};
      ADDR_W'(OFS_CTRL):  rd_mux = ctrl_image(code_field, dma_done_mode, little_endian);
      ADDR_W'(OFS_IADDR): rd_mux = in_addr;
      ADDR_W'(OFS_ICNT):  rd_mux = {{(32-CNT_W){1'b0}}, in_count};
      ADDR_W'(OFS_HADDR): rd_mux = hdr_addr;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R13
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R13

endmodule

// File: tb/dec_csr_regs_bench.sv
module dec_csr_regs_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        d_valid = 0, d_write = 0;
  logic [2:0]  d_addr = '0;
  logic [31:0] d_wdata = '0;
  logic        d_cmd = 0, d_sc = 0, d_err = 0, d_issue = 0, d_dec = 0;
  logic        d_b0 = 0, d_b1 = 0;

  logic        rd_valid, irq, little_endian, dma_done_mode;
  logic [31:0] rd_data, in_addr, hdr_addr;
  logic [7:0]  restart_code;
  logic [14:0] in_count;

  dec_csr_regs u_dec_csr_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(d_valid), .req_write(d_write),
    .req_addr(d_addr), .req_wdata(d_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ev_cmd_done(d_cmd), .ev_start_code(d_sc), .ev_bs_error(d_err),
    .cmd_issue(d_issue), .dma_dec(d_dec), .buf0_empty(d_b0), .buf1_empty(d_b1),
    .irq(irq), .little_endian(little_endian), .dma_done_mode(dma_done_mode),
    .restart_code(restart_code), .in_addr(in_addr), .in_count(in_count),
    .hdr_addr(hdr_addr)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  logic [3:0]  m_flags;
  logic [7:0]  m_en, m_field, m_work;
  logic        m_le, m_mode, m_pend;
  logic [31:0] m_iaddr, m_haddr;
  logic [14:0] m_cnt;

  task automatic model_reset();
    m_flags = '0; m_en = '0; m_field = '0; m_work = '0;
    m_le = 1'b1; m_mode = 1'b0; m_pend = 1'b0;
    m_iaddr = '0; m_haddr = '0; m_cnt = '0;
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {28'd0, m_flags};
      3'd1: return {24'd0, m_en};
      3'd2: return {16'd0, m_field, 5'd0, m_mode, 1'b0, m_le};
      3'd3: return m_iaddr;
      3'd4: return {17'd0, m_cnt};
      3'd5: return m_haddr;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |({4'd0, m_flags} & m_en);
  endfunction

  task automatic model_step();
    logic wr, cw, fire, zero, dset;
    logic [3:0] nf;
    wr   = d_valid && d_write;
    cw   = wr && d_addr == 3'd4;
    fire = d_dec && !cw && m_cnt != 0;
    zero = fire && m_cnt == 15'd1;
    dset = m_mode ? ((zero || m_pend) && d_b0 && d_b1) : zero;
    nf[0] = d_cmd ? 1'b1 : (d_issue ? 1'b0 : m_flags[0]);
    nf[1] = d_sc  ? 1'b1 : ((wr && d_addr == 0 && d_wdata[1]) ? 1'b0 : m_flags[1]);
    nf[2] = d_err ? 1'b1 : ((wr && d_addr == 0 && d_wdata[2]) ? 1'b0 : m_flags[2]);
    nf[3] = dset  ? 1'b1 : ((wr && d_addr == 0 && d_wdata[3]) ? 1'b0 : m_flags[3]);
    if (cw && d_wdata[14:0] != 0)  m_pend = 1'b0;
    else if (!m_mode || dset)      m_pend = 1'b0;
    else if (zero)                 m_pend = 1'b1;
    if (cw) m_cnt = d_wdata[14:0];
    else if (fire) m_cnt = m_cnt - 15'd1;
    m_flags = nf;
    if (wr && d_addr == 3'd1) m_en = d_wdata[7:0];
    if (wr && d_addr == 3'd2) begin
      m_field = d_wdata[15:8];
      if (d_wdata[16]) m_work = d_wdata[15:8];
      else begin m_le = d_wdata[0]; m_mode = d_wdata[2]; end
    end
    if (wr && d_addr == 3'd3) m_iaddr = d_wdata & ~32'd3;
    if (wr && d_addr == 3'd5) m_haddr = d_wdata & ~32'd3;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic rdreq;
    logic [31:0] erd;
    rdreq = d_valid && !d_write;
    erd = exp_rd(d_addr);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R13 rd_valid", {31'd0, rd_valid}, {31'd0, rdreq});
    if (rdreq) chk("R13 rd_data", rd_data, erd);
    chk("R5 irq", {31'd0, irq}, {31'd0, exp_irq()});
    chk("R7 le", {31'd0, little_endian}, {31'd0, m_le});
    chk("R7 mode", {31'd0, dma_done_mode}, {31'd0, m_mode});
    chk("R6 code", {24'd0, restart_code}, {24'd0, m_work});
    chk("R12 iaddr", in_addr, m_iaddr);
    chk("R12 haddr", hdr_addr, m_haddr);
    chk("R8 count", {17'd0, in_count}, {17'd0, m_cnt});
    d_valid = 0; d_write = 0; d_cmd = 0; d_sc = 0; d_err = 0; d_issue = 0; d_dec = 0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    d_valid = 1; d_write = 1; d_addr = a; d_wdata = d;
    tick();
  endtask

  task automatic rreg(input logic [2:0] a, input logic [31:0] e, input string req);
    d_valid = 1; d_write = 0; d_addr = a;
    tick();
    chk(req, rd_data, e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 le", {31'd0, little_endian}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 code", {24'd0, restart_code}, 32'd0);
    rreg(3'd2, 32'h1, "R1 ctrl");
    rreg(3'd0, 32'h0, "R1 flags");
    rreg(3'd4, 32'h0, "R1 count");

    // R2 write-one-to-clear
    d_sc = 1; tick();
    wreg(3'd0, 32'h0);
    rreg(3'd0, 32'h2, "R2 zero write keeps");
    wreg(3'd0, 32'h2);
    rreg(3'd0, 32'h0, "R2 one write clears");

    // R3 command-done clears only on issue
    d_cmd = 1; tick();
    wreg(3'd0, 32'hF);
    rreg(3'd0, 32'h1, "R3 w1 ignored");
    d_issue = 1; tick();
    rreg(3'd0, 32'h0, "R3 issue clears");

    // R4 set beats clear
    d_err = 1; d_valid = 1; d_write = 1; d_addr = 3'd0; d_wdata = 32'h4; tick();
    rreg(3'd0, 32'h4, "R4 set wins");

    // R5 mask gating
    wreg(3'd1, 32'hFFFF_FF04);
    chk("R5 irq on", {31'd0, irq}, 32'd1);
    rreg(3'd1, 32'h04, "R5 mask width");
    wreg(3'd1, 32'h0000_0002);
    chk("R5 irq off", {31'd0, irq}, 32'd0);
    wreg(3'd0, 32'h4);

    // R6 strobe load
    wreg(3'd2, 32'h0001_5A00);
    chk("R6 code loaded", {24'd0, restart_code}, 32'h5A);
    rreg(3'd2, 32'h0000_5A01, "R6 strobe reads 0");
    wreg(3'd2, 32'h0000_3300);
    chk("R6 no strobe no load", {24'd0, restart_code}, 32'h5A);

    // R7 gated mode bits
    wreg(3'd2, 32'h0000_0004);
    chk("R7 le written", {31'd0, little_endian}, 32'd0);
    chk("R7 mode written", {31'd0, dma_done_mode}, 32'd1);
    wreg(3'd2, 32'h0001_0001);
    chk("R7 le held", {31'd0, little_endian}, 32'd0);
    chk("R7 mode held", {31'd0, dma_done_mode}, 32'd1);

    // R8 count width and decrement
    wreg(3'd4, 32'hFFFF_FFFF);
    rreg(3'd4, 32'h7FFF, "R8 width");
    d_dec = 1; tick();
    chk("R8 dec", {17'd0, in_count}, 32'h7FFE);
    d_dec = 1; d_valid = 1; d_write = 1; d_addr = 3'd4; d_wdata = 32'h9; tick();
    chk("R8 write wins", {17'd0, in_count}, 32'h9);

    // R9 mode 0 done on drain
    wreg(3'd2, 32'h0000_0000);
    wreg(3'd4, 32'h2);
    d_dec = 1; tick();
    rreg(3'd0, 32'h0, "R9 not yet");
    d_dec = 1; tick();
    rreg(3'd0, 32'h8, "R9 drained");
    d_dec = 1; tick();
    chk("R8 zero stays", {17'd0, in_count}, 32'h0);
    wreg(3'd0, 32'h8);

    // R10 mode 1 waits for empty buffers
    wreg(3'd2, 32'h0000_0004);
    wreg(3'd4, 32'h1);
    d_b0 = 1; d_b1 = 0;
    d_dec = 1; tick();
    idle(3);
    rreg(3'd0, 32'h0, "R10 pending held");
    d_b1 = 1; tick();
    rreg(3'd0, 32'h8, "R10 both empty sets");
    wreg(3'd0, 32'h8);

    // R11 new count cancels pending
    d_b0 = 0; d_b1 = 0;
    wreg(3'd4, 32'h1);
    d_dec = 1; tick();
    wreg(3'd4, 32'h5);
    d_b0 = 1; d_b1 = 1; idle(2);
    rreg(3'd0, 32'h0, "R11 cancelled");

    // R12 alignment
    wreg(3'd3, 32'h1234_5677);
    rreg(3'd3, 32'h1234_5674, "R12 in addr");
    wreg(3'd5, 32'hDEAD_BEEF);
    rreg(3'd5, 32'hDEAD_BEEC, "R12 hdr addr");

    // R13 unmapped offsets
    rreg(3'd6, 32'h0, "R13 unmapped 6");
    rreg(3'd7, 32'h0, "R13 unmapped 7");

    // random phase, checked against the reference each cycle
    for (int n = 0; n < 4000; n++) begin
      d_cmd   = ($urandom_range(0, 7) == 0);
      d_sc    = ($urandom_range(0, 7) == 0);
      d_err   = ($urandom_range(0, 7) == 0);
      d_issue = ($urandom_range(0, 7) == 0);
      d_dec   = $urandom_range(0, 1);
      d_b0    = $urandom_range(0, 1);
      d_b1    = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) begin
        d_valid = 1;
        d_write = $urandom_range(0, 1);
        d_addr  = 3'($urandom_range(0, 7));
        d_wdata = $urandom();
        if (d_addr == 3'd4) d_wdata = 32'($urandom_range(0, 3));
      end
      tick();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule